// File: doc/BRIEF.md
# Queue-Depth Capacity Fraction Unit

This block turns the depth of an output queue into the share of the link's total capacity that may be handed out to rate-controlled sources. At each end-of-interval strobe it samples the queue length, a target queue length, the total capacity and three shape settings. It then works out a fraction from two hyperbolic segments that meet at the target depth. Below the target the fraction is at least one, and it rises to the lower slope setting as the queue empties. Above the target the fraction is at most one, and it falls with depth until a drain floor stops it. The block outputs the fraction and the capacity scaled by it.

The target depth is the wanted queueing delay converted to cells at the drain rate, typically a delay of 0.5 ms to 2 ms. The lower slope setting normally lies in [1.0, 1.05]. The upper one lies in [1.10, 1.25], and the drain floor defaults to 0.5. All ratios use unsigned fixed point with 2 integer and 14 fraction bits, so 1.0 is raw 16384. A sequential divider produces one result for each accepted strobe, and a done pulse marks the cycle in which new outputs appear.

Top module: `qdelay_cap_fraction`

## Requirements
- R1: A strobe on `eval` is accepted only while no evaluation is in progress. `done` is a single-cycle pulse that first appears 17 clock cycles after the rising edge that accepted the strobe.
- R2: With target depth Q0 nonzero and queue length q at most Q0, `frac` equals floor(b·Q0·16384 / ((b−16384)·q + Q0·16384)), where b is the raw lower slope.
- R3: With Q0 nonzero and q above Q0, `frac` is the same expression using the raw upper slope a. A result below the raw drain floor is replaced by the floor.
- R4: With Q0 nonzero and a slope of at least 16384, q equal to Q0 gives exactly 16384, and q equal to 0 gives exactly b.
- R5: A lower slope of exactly 16384 gives a constant fraction of 16384 for every q from 0 to Q0.
- R6: A slope below 16384 is treated as flat, so its excess over one counts as zero. The fraction then equals that slope, and the drain floor still applies above Q0.
- R7: With Q0 zero, an empty queue gives `frac` equal to b, and any nonzero queue gives `frac` equal to the drain floor.
- R8: `tgt_cap` equals floor(frac·abr_cap / 16384) and is 26 bits wide.
- R9: A strobe during an evaluation is ignored, and so are input changes after the accepting edge. `frac` and `tgt_cap` change only in the cycle in which `done` is high.
- R10: After reset, `frac`, `tgt_cap` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval | input | 1 | End-of-interval strobe |
| qlen | input | 20 | Current queue length in cells |
| qtarget | input | 20 | Target queue length Q0 in cells |
| abr_cap | input | 24 | Total capacity available to the controlled class |
| slope_lo | input | 16 | Lower-segment slope b, Q2.14 |
| slope_hi | input | 16 | Upper-segment slope a, Q2.14 |
| drain_floor | input | 16 | Minimum fraction above the target, Q2.14 |
| frac | output | 16 | Capacity fraction, Q2.14 |
| tgt_cap | output | 26 | Target capacity |
| done | output | 1 | One-cycle pulse when outputs update |

## Verification
A divider that takes a wrong branch or drops a shift corrupts the quotient. That shows up on `frac` and `tgt_cap` in the done cycle of that same evaluation, so each scoreboard comparison against the integer model exposes it at once. A wrong segment choice, a missing floor or a bad Q0-zero path shows as a value that breaks the unity, floor or empty-queue identities in that done cycle. A sequencer that miscounts moves the done pulse away from its 17-cycle slot. It can also emit an extra pulse, which the scoreboard sees as a result it never expected.

// File: rtl/qdelay_cap_fraction.sv
`timescale 1ns/1ps
module qdelay_cap_fraction #(
  parameter int QW   = 20,
  parameter int FW   = 16,
  parameter int FRAC = 14,
  parameter int CW   = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval,
  input  logic [QW-1:0]   qlen,
  input  logic [QW-1:0]   qtarget,
  input  logic [CW-1:0]   abr_cap,
  input  logic [FW-1:0]   slope_lo,
  input  logic [FW-1:0]   slope_hi,
  input  logic [FW-1:0]   drain_floor,
  output logic [FW-1:0]   frac,
  output logic [CW+1:0]   tgt_cap,
  output logic            done
);
  localparam int DIVW = FW + QW + FRAC;
  localparam int DENW = FW + QW + 1;
  localparam int CNTW = $clog2(FW) + 1;
  localparam logic [FW-1:0] ONE = FW'(1) << FRAC;

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;
  st_t st;

  logic            idle;
  logic            seg_hi_r, eq_r, qz_r, q0z_r;
  logic [FW-1:0]   coef_r, floor_r, wq_r;
  logic [CW-1:0]   cap_r;
  logic [DENW-1:0] den_r, rem_r;
  logic [CNTW-1:0] cnt;

  assign idle = (st == IDLE);

  logic            seg_hi_c;
  logic [FW-1:0]   coef_c, km1_c;
  logic [DENW-1:0] den_c;
  logic [DIVW-1:0] dvd_c;

  assign seg_hi_c = qlen > qtarget;
  assign coef_c   = seg_hi_c ? slope_hi : slope_lo;
  assign km1_c    = (coef_c > ONE) ? coef_c - ONE : '0;
  assign den_c    = DENW'(km1_c) * DENW'(qlen) + (DENW'(qtarget) << FRAC);
  assign dvd_c    = (DIVW'(coef_c) * DIVW'(qtarget)) << FRAC;

  logic [DENW:0]   rem_sh, diff;
  logic            take;

  assign rem_sh = {rem_r, wq_r[FW-1]};
  assign take   = rem_sh >= {1'b0, den_r};
  assign diff   = rem_sh - {1'b0, den_r};

  logic [FW-1:0]    res;
  logic [CW+FW-1:0] prod;

  always_comb begin
    if (q0z_r)
      res = qz_r ? coef_r : floor_r;
    else if (seg_hi_r && (wq_r < floor_r))
      res = floor_r;
    else
      res = wq_r;
  end

  assign prod = (CW+FW)'(res) * (CW+FW)'(cap_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      done     <= 1'b0;
      frac     <= '0;
      tgt_cap  <= '0;
      cnt      <= '0;
      rem_r    <= '0;
      wq_r     <= '0;
      den_r    <= '0;
      coef_r   <= '0;
      floor_r  <= '0;
      cap_r    <= '0;
      seg_hi_r <= 1'b0;
      eq_r     <= 1'b0;
      qz_r     <= 1'b0;
      q0z_r    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (eval) begin
          seg_hi_r <= seg_hi_c;
          eq_r     <= (qlen == qtarget);
          qz_r     <= (qlen == '0);
          q0z_r    <= (qtarget == '0);
          coef_r   <= coef_c;
          floor_r  <= drain_floor;
          cap_r    <= abr_cap;
          den_r    <= den_c;
          rem_r    <= DENW'(dvd_c[DIVW-1:FW]);
          wq_r     <= dvd_c[FW-1:0];
          cnt      <= '0;
          st       <= RUN;
        end
        RUN: begin
          rem_r <= take ? diff[DENW-1:0] : rem_sh[DENW-1:0];
          wq_r  <= {wq_r[FW-2:0], take};
          cnt   <= cnt + 1'b1;
          if (cnt == CNTW'(FW-1)) st <= FIN;
        end
        FIN: begin
          frac    <= res;
          tgt_cap <= prod[FRAC +: CW+2];
          done    <= 1'b1;
          st      <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qdelay_cap_fraction_chk.sv
`timescale 1ns/1ps
module qdelay_cap_fraction_chk #(
  parameter int FW   = 16,
  parameter int FRAC = 14,
  parameter int CW   = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eval,
  input logic          idle,
  input logic          done,
  input logic [FW-1:0] frac,
  input logic [CW+1:0] tgt_cap,
  input logic          seg_hi_r,
  input logic          eq_r,
  input logic          qz_r,
  input logic          q0z_r,
  input logic [FW-1:0] coef_r,
  input logic [FW-1:0] floor_r
);
  logic [7:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lat <= '0;
    else if (eval && idle)  lat <= 8'd1;
    else if (done)          lat <= '0;
    else if (lat != '0)     lat <= lat + 8'd1;
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R1
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> lat == 8'(FW + 2));

  // R9
  hold_frac_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(frac) && $stable(tgt_cap)));

  // R3
  drain_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && seg_hi_r && !q0z_r) |-> frac >= floor_r);

  // R4
  unity_at_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && eq_r && !q0z_r && coef_r >= (FW'(1) << FRAC)) |-> frac == (FW'(1) << FRAC));

  // R7
  zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && q0z_r) |-> frac == (qz_r ? coef_r : floor_r));
endmodule

bind qdelay_cap_fraction qdelay_cap_fraction_chk #(.FW(FW), .FRAC(FRAC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eval(eval), .idle(idle), .done(done),
  .frac(frac), .tgt_cap(tgt_cap), .seg_hi_r(seg_hi_r), .eq_r(eq_r),
  .qz_r(qz_r), .q0z_r(q0z_r), .coef_r(coef_r), .floor_r(floor_r)
);

// File: tb/qdelay_cap_fraction_test.sv
`timescale 1ns/1ps
module qdelay_cap_fraction_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval = 1'b0;
  logic [19:0] qlen = '0, qtarget = '0;
  logic [23:0] abr_cap = '0;
  logic [15:0] slope_lo = '0, slope_hi = '0, drain_floor = '0;
  logic [15:0] frac;
  logic [25:0] tgt_cap;
  logic        done;

  always #2 clk = ~clk;

  qdelay_cap_fraction uut (
    .clk(clk), .rst_n(rst_n), .eval(eval), .qlen(qlen), .qtarget(qtarget),
    .abr_cap(abr_cap), .slope_lo(slope_lo), .slope_hi(slope_hi),
    .drain_floor(drain_floor), .frac(frac), .tgt_cap(tgt_cap), .done(done)
  );

  int checks = 0, fails = 0, cyc = 0, last_f = 0;
  bit over = 0;
  int     ef[$];
  longint et[$];
  int     ec[$];
  string  er[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void model(longint q, longint q0, longint cap, longint b, longint a,
                                longint fl, output int f, output longint t);
    longint k, km1, den, fv;
    if (q0 == 0) fv = (q == 0) ? b : fl;
    else begin
      k   = (q > q0) ? a : b;
      km1 = (k > 16384) ? k - 16384 : 0;
      den = km1 * q + q0 * 16384;
      fv  = (k * q0 * 16384) / den;
      if (q > q0 && fv < fl) fv = fl;
    end
    f = int'(fv);
    t = (fv * cap) >> 14;
  endfunction

  task automatic go(int q, int q0, int cap, int b, int a, int fl, string req);
    int f; longint t;
    wait (ef.size() == 0);
    @(negedge clk);
    qlen = 20'(q); qtarget = 20'(q0); abr_cap = 24'(cap);
    slope_lo = 16'(b); slope_hi = 16'(a); drain_floor = 16'(fl);
    eval = 1'b1;
    @(negedge clk);
    eval = 1'b0;
    model(q, q0, cap, b, a, fl, f, t);
    ef.push_back(f); et.push_back(t); ec.push_back(cyc); er.push_back(req);
    qlen = 20'($urandom); qtarget = 20'($urandom); abr_cap = 24'($urandom);
    slope_lo = 16'($urandom); slope_hi = 16'($urandom); drain_floor = 16'($urandom);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (ef.size() == 0) chk(1'b0, "R9", "unexpected done", 1, 0);
      else begin
        int f; longint t; int c0; string r;
        f = ef.pop_front(); t = et.pop_front(); c0 = ec.pop_front(); r = er.pop_front();
        chk(frac == 16'(f), r, "frac", frac, f);
        chk(tgt_cap == 26'(t), "R8", "tgt_cap", tgt_cap, t);
        chk(cyc - c0 == 17, "R1", "latency", cyc - c0, 17);
        last_f = int'(frac);
      end
    end
  end

  localparam int B = 16712, A = 18842, FL = 8192, Q0 = 1000, CAP = 353207;

  initial begin
    repeat (3) @(negedge clk);
    chk(frac == 0, "R10", "reset frac", frac, 0);
    chk(tgt_cap == 0, "R10", "reset tgt_cap", tgt_cap, 0);
    chk(done == 0, "R10", "reset done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    go(0,    Q0, CAP, B, A, FL, "R4");
    go(Q0,   Q0, CAP, B, A, FL, "R4");
    go(500,  Q0, CAP, B, A, FL, "R2");
    go(37,   Q0, CAP, B, A, FL, "R2");
    go(2000, Q0, CAP, B, A, FL, "R3");
    go(1001, Q0, CAP, B, A, FL, "R3");
    go(1048575, Q0, CAP, B, A, FL, "R3");
    go(0,    Q0, CAP, 16384, A, FL, "R5");
    go(700,  Q0, CAP, 16384, A, FL, "R5");
    go(Q0,   Q0, CAP, 16384, A, FL, "R5");
    go(3000, Q0, CAP, B, 14746, FL, "R6");
    go(300,  Q0, CAP, 15000, A, FL, "R6");
    go(3000, Q0, CAP, B, 4000, FL, "R6");
    go(0,    0,  CAP, B, A, FL, "R7");
    go(5,    0,  CAP, B, A, FL, "R7");
    go(1048575, 1048575, 16777215, B, A, FL, "R4");
    go(0, 1048575, 16777215, 65535, A, FL, "R2");

    wait (ef.size() == 0);
    go(2500, Q0, CAP, B, A, FL, "R9");
    wait (ef.size() == 0);
    repeat (2) @(negedge clk);
    go(200, Q0, 1234567, B, A, FL, "R9");
    repeat (4) @(negedge clk);
    qlen = 20'd9000; qtarget = 20'd10; eval = 1'b1;
    @(negedge clk);
    eval = 1'b0;
    chk(int'(frac) == last_f, "R9", "frac held during busy", frac, last_f);
    wait (ef.size() == 0);
    repeat (30) @(negedge clk);
    chk(ef.size() == 0, "R9", "no extra result", ef.size(), 0);

    for (int i = 0; i < 24; i++) begin
      go(int'($urandom_range(12000, 0)), int'($urandom_range(4000, 1)),
         int'($urandom_range(16777215, 0)), int'($urandom_range(17203, 16384)),
         int'($urandom_range(20480, 18022)), FL, "R2");
    end

    wait (ef.size() == 0);
    repeat (5) @(negedge clk);
    over = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      over = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule